// File: doc/BRIEF.md
# Queue Interrupt Source Selector

This block turns the status flags of 64 hardware queues into two interrupt lines. One line serves the lower 32 queues and the other serves the upper 32. For each lower queue, software chooses which of that queue's four status flags drives its interrupt, and may invert that flag. Every upper queue has a fixed condition: its nearly-empty flag is low.

A pending bit is set when a queue's condition goes from 0 to 1 while the queue is enabled. Pending bits stay set until software writes ones to clear them, or until the queue's enable is cleared. Each interrupt line is high while any queue in its half is both pending and enabled. Software reaches the source codes, the enable masks and the pending bits through a small register port with eight word addresses. The port takes writes in one cycle and returns read data combinationally.

Top module: `qirq_select`

## Requirements
- R1: After a synchronous reset, every register word (addresses 0 to 7) reads zero and both `irq_lo` and `irq_hi` are low.
- R2: Addresses 0 to 3 hold the source codes for lower queues 8w to 8w+7, where w is the address. Queue q uses bits (q%8)*4+3 down to (q%8)*4 of its word. Within that slot, bits 1:0 select a flag index and bit 2 inverts the condition. Bit 3 is reserved, ignores writes and reads 0.
- R3: A lower queue's condition is `lo_flags[q*4+f] XOR inv`, where f and inv come from its source code. The pending bit sets at the clock edge where the condition is 1 and was 0 at the previous edge.
- R4: An upper queue's condition is `NOT hi_nearly_empty[q]`, with the same rising-edge rule for setting its pending bit.
- R5: A pending bit is never set while the queue's enable bit (address 4 for the lower half, address 5 for the upper half) is 0.
- R6: Writing to address 6 (lower half) or address 7 (upper half) clears each pending bit written as one. Bits written as zero are left unchanged.
- R7: Clearing a queue's enable bit also clears its pending bit at the same edge.
- R8: `irq_lo` and `irq_hi` are each the OR, across the 32 queues of their half, of pending AND enable.
- R9: When a set event and a clearing write hit the same pending bit at the same edge, the bit ends up set.
- R10: A condition that stays at 1 does not set its pending bit again after that bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| lo_flags | input | 128 | Four status flags per lower queue; flag f of queue q is at bit q*4+f |
| hi_nearly_empty | input | 32 | Nearly-empty flag of each upper queue |
| irq_lo | output | 1 | Interrupt line for queues 0 to 31 |
| irq_hi | output | 1 | Interrupt line for queues 32 to 63 |

## Verification
The properties assume that the status flags and the register port are stable at every rising edge and never hold unknown values once reset has been applied. The clear-only-by-write property also assumes that every address in the 3-bit range decodes to a real register. The bench meets these assumptions by driving reset from time zero. It changes flags and register strobes only on falling edges, and it never leaves the register port half-driven. Because setting is edge-based, each scenario first holds a flag at its inactive level for at least one edge before it raises that flag.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int HALF_Q         = 32;
    localparam int FLAG_N         = 4;
    localparam int SLOT_W         = 4;
    localparam int SLOTS_PER_WORD = 8;
    localparam int SRC_WORDS      = HALF_Q / SLOTS_PER_WORD;
    localparam int ADDR_W         = 3;
    localparam int DATA_W         = 32;
    localparam int FLAG_SEL_W     = $clog2(FLAG_N);

    typedef struct packed {
        logic                  inv;
        logic [FLAG_SEL_W-1:0] flag;
    } src_code_t;

    localparam int CODE_W = $bits(src_code_t);

    typedef enum logic [ADDR_W-1:0] {
        A_SRC0    = 3'd0,
        A_SRC1    = 3'd1,
        A_SRC2    = 3'd2,
        A_SRC3    = 3'd3,
        A_EN_LO   = 3'd4,
        A_EN_HI   = 3'd5,
        A_PEND_LO = 3'd6,
        A_PEND_HI = 3'd7
    } reg_sel_e;

    function automatic logic [SLOT_W-1:0] slot_of(src_code_t c);
        return {{(SLOT_W-CODE_W){1'b0}}, c};
    endfunction

    function automatic src_code_t code_of(logic [SLOT_W-1:0] s);
        return src_code_t'(s[CODE_W-1:0]);
    endfunction

endpackage

// File: rtl/qirq_lo_cond.sv
module qirq_lo_cond
    import qirq_pkg::*;
#(
    parameter int N = HALF_Q
) (
    input  src_code_t          src   [N],
    input  logic [N*FLAG_N-1:0] flags,
    output logic [N-1:0]        cond
);
    for (genvar q = 0; q < N; q++) begin : g_q
        logic [FLAG_N-1:0] fl;
        assign fl      = flags[q*FLAG_N +: FLAG_N];
        assign cond[q] = fl[src[q].flag] ^ src[q].inv;
    end
endmodule

// File: rtl/qirq_half.sv
module qirq_half
    import qirq_pkg::*;
#(
    parameter int N = HALF_Q
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic         en_we,
    input  logic         pend_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q,
    output logic [N-1:0] pend_q,
    output logic         irq
);
    logic [N-1:0] prev_q;
    logic [N-1:0] en_nxt, dropped, rise, set_v, clr_v;

    always_comb begin
        en_nxt  = en_we ? wdata : en_q;
        dropped = en_q & ~en_nxt;
        rise    = cond & ~prev_q;
        set_v   = rise & en_nxt;
        clr_v   = (pend_we ? wdata : '0) | dropped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= cond;
            en_q   <= en_nxt;
            pend_q <= (pend_q & ~clr_v) | set_v;
        end
    end

    assign irq = |(pend_q & en_q);
endmodule

// File: rtl/qirq_select.sv
module qirq_select
    import qirq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [HALF_Q*FLAG_N-1:0] lo_flags,
    input  logic [HALF_Q-1:0]        hi_nearly_empty,
    output logic                     irq_lo,
    output logic                     irq_hi
);
    localparam int WSEL_W = $clog2(SRC_WORDS);

    src_code_t         src_q [HALF_Q];
    logic [HALF_Q-1:0] cond_lo, cond_hi;
    logic [HALF_Q-1:0] en_lo_q, en_hi_q, pend_lo_q, pend_hi_q;
    logic              src_hit;
    logic [WSEL_W-1:0] wsel;

    assign src_hit = (reg_addr < ADDR_W'(SRC_WORDS));
    assign wsel    = reg_addr[WSEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF_Q; i++) src_q[i] <= '0;
        end else if (reg_wr && src_hit) begin
            for (int i = 0; i < HALF_Q; i++) begin
                if (wsel == WSEL_W'(i / SLOTS_PER_WORD))
                    src_q[i] <= code_of(reg_wdata[(i % SLOTS_PER_WORD)*SLOT_W +: SLOT_W]);
            end
        end
    end

    qirq_lo_cond #(.N(HALF_Q)) u_cond (
        .src   (src_q),
        .flags (lo_flags),
        .cond  (cond_lo)
    );

    assign cond_hi = ~hi_nearly_empty;

    qirq_half #(.N(HALF_Q)) u_lo (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond_lo),
        .en_we   (reg_wr && reg_addr == A_EN_LO),
        .pend_we (reg_wr && reg_addr == A_PEND_LO),
        .wdata   (reg_wdata[HALF_Q-1:0]),
        .en_q    (en_lo_q),
        .pend_q  (pend_lo_q),
        .irq     (irq_lo)
    );

    qirq_half #(.N(HALF_Q)) u_hi (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond_hi),
        .en_we   (reg_wr && reg_addr == A_EN_HI),
        .pend_we (reg_wr && reg_addr == A_PEND_HI),
        .wdata   (reg_wdata[HALF_Q-1:0]),
        .en_q    (en_hi_q),
        .pend_q  (pend_hi_q),
        .irq     (irq_hi)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN_LO:   reg_rdata = en_lo_q;
            A_EN_HI:   reg_rdata = en_hi_q;
            A_PEND_LO: reg_rdata = pend_lo_q;
            A_PEND_HI: reg_rdata = pend_hi_q;
            default: begin
                for (int s = 0; s < SLOTS_PER_WORD; s++)
                    reg_rdata[s*SLOT_W +: SLOT_W] =
                        slot_of(src_q[int'(wsel)*SLOTS_PER_WORD + s]);
            end
        endcase
    end
endmodule

// File: rtl/qirq_select_chk.sv
module qirq_select_chk
    import qirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [HALF_Q-1:0] hi_nearly_empty,
    input logic [HALF_Q-1:0] en_lo_q,
    input logic [HALF_Q-1:0] en_hi_q,
    input logic [HALF_Q-1:0] pend_lo_q,
    input logic [HALF_Q-1:0] pend_hi_q,
    input logic              irq_lo,
    input logic              irq_hi
);
    localparam logic [DATA_W-1:0] RSV_MASK = 32'h8888_8888;

    logic [HALF_Q-1:0] wclr_lo, wclr_hi;
    assign wclr_lo = (reg_wr && reg_addr == A_PEND_LO) ? reg_wdata[HALF_Q-1:0] : '0;
    assign wclr_hi = (reg_wr && reg_addr == A_PEND_HI) ? reg_wdata[HALF_Q-1:0] : '0;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pend_lo_q == '0 && pend_hi_q == '0 && en_lo_q == '0 && en_hi_q == '0
                 && !irq_lo && !irq_hi));

    // R2
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < ADDR_W'(SRC_WORDS)) |-> ((reg_rdata & RSV_MASK) == '0));

    // R5
    a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_lo_q & ~$past(pend_lo_q) & ~en_lo_q) == '0) &&
                  ((pend_hi_q & ~$past(pend_hi_q) & ~en_hi_q) == '0)));

    // R4
    a_r4_hi_needs_low_ne: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_hi_q & ~$past(pend_hi_q) & $past(hi_nearly_empty)) == '0));

    // R7
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_lo_q & $past(en_lo_q) & ~en_lo_q) == '0) &&
                  ((pend_hi_q & $past(en_hi_q) & ~en_hi_q) == '0)));

    // R6
    a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((($past(pend_lo_q) & ~pend_lo_q) &
                    ~($past(wclr_lo) | ($past(en_lo_q) & ~en_lo_q))) == '0) &&
                  ((($past(pend_hi_q) & ~pend_hi_q) &
                    ~($past(wclr_hi) | ($past(en_hi_q) & ~en_hi_q))) == '0)));
endmodule

bind qirq_select qirq_select_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .hi_nearly_empty (hi_nearly_empty),
    .en_lo_q         (en_lo_q),
    .en_hi_q         (en_hi_q),
    .pend_lo_q       (pend_lo_q),
    .pend_hi_q       (pend_hi_q),
    .irq_lo          (irq_lo),
    .irq_hi          (irq_hi)
);

// File: tb/qirq_select_test.sv
module qirq_select_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [31:0]  reg_wdata = 32'd0;
    logic [31:0]  reg_rdata;
    logic [127:0] lo_flags = '0;
    logic [31:0]  hi_ne = '1;
    logic         irq_lo, irq_hi;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qirq_select uut (
        .clk             (clk),
        .rst             (rst),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .lo_flags        (lo_flags),
        .hi_nearly_empty (hi_ne),
        .irq_lo          (irq_lo),
        .irq_hi          (irq_hi)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_chk("R1 reg", 3'(a), 32'd0);
        chk("R1 irq_lo", {31'd0, irq_lo}, 32'd0);
        chk("R1 irq_hi", {31'd0, irq_hi}, 32'd0);
    endtask

    task automatic t_src_map;
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk("R2 reserved bits", 3'd1, 32'h7777_7777);
        rd_chk("R2 other word", 3'd0, 32'd0);
        wr(3'd1, 32'd0);
        rd_chk("R2 cleared", 3'd1, 32'd0);
    endtask

    task automatic t_lo_select;
        wr(3'd1, 32'h0000_0200);
        wr(3'd4, 32'h0000_0400);
        lo_flags[10*4+0] = 1'b1;
        step; step;
        rd_chk("R3 wrong flag ignored", 3'd6, 32'd0);
        lo_flags[10*4+0] = 1'b0;
        lo_flags[10*4+2] = 1'b1;
        step;
        rd_chk("R3 selected flag sets", 3'd6, 32'h0000_0400);
        chk("R8 irq_lo high", {31'd0, irq_lo}, 32'd1);
        chk("R8 irq_hi low", {31'd0, irq_hi}, 32'd0);
    endtask

    task automatic t_clear;
        wr(3'd6, 32'hFFFF_FBFF);
        rd_chk("R6 zero bits no effect", 3'd6, 32'h0000_0400);
        wr(3'd6, 32'h0000_0400);
        rd_chk("R6 ones clear", 3'd6, 32'd0);
        step; step;
        rd_chk("R10 held level no reset", 3'd6, 32'd0);
        chk("R8 irq_lo low after clear", {31'd0, irq_lo}, 32'd0);
    endtask

    task automatic t_invert;
        wr(3'd0, 32'h0000_5000);
        step;
        wr(3'd4, 32'h0000_0408);
        step;
        rd_chk("R3 inverted steady no set", 3'd6, 32'd0);
        lo_flags[3*4+1] = 1'b1;
        step;
        rd_chk("R3 inverted falling cond", 3'd6, 32'd0);
        lo_flags[3*4+1] = 1'b0;
        step;
        rd_chk("R3 inverted rise sets", 3'd6, 32'h0000_0008);
        chk("R8 irq_lo inverted", {31'd0, irq_lo}, 32'd1);
    endtask

    task automatic t_hi;
        wr(3'd5, 32'h0000_0020);
        hi_ne[5] = 1'b0;
        step;
        rd_chk("R4 hi not nearly empty sets", 3'd7, 32'h0000_0020);
        chk("R8 irq_hi high", {31'd0, irq_hi}, 32'd1);
        hi_ne[5] = 1'b1;
        step;
        rd_chk("R4 ne high keeps pending", 3'd7, 32'h0000_0020);
        hi_ne[6] = 1'b0;
        step;
        rd_chk("R5 disabled queue no set", 3'd7, 32'h0000_0020);
    endtask

    task automatic t_disable;
        wr(3'd5, 32'd0);
        rd_chk("R7 disable clears pending", 3'd7, 32'd0);
        chk("R7 irq_hi low", {31'd0, irq_hi}, 32'd0);
        wr(3'd4, 32'h0000_0400);
        rd_chk("R7 lower bit3 cleared", 3'd6, 32'd0);
    endtask

    task automatic t_set_wins;
        wr(3'd5, 32'h0000_0080);
        step;
        @(negedge clk);
        hi_ne[7] = 1'b0;
        reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 32'h0000_0080;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
        rd_chk("R9 set beats clear", 3'd7, 32'h0000_0080);
        chk("R9 irq_hi", {31'd0, irq_hi}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step;
        t_reset;
        t_src_map;
        t_lo_select;
        t_clear;
        t_invert;
        t_hi;
        t_disable;
        t_set_wins;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule